// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Sequencer

This block takes an asynchronous, socketed DRAM module from power-up to normal service and then keeps its contents alive. After reset it first holds every strobe inactive for a programmable settling pause. It then issues a fixed burst of initialization cycles, all of them refresh cycles, without asking anyone. Only after that does it signal that the module is ready. From then on it counts a refresh interval sized so that every row is visited within the retention window. Each expiry adds one owed refresh to a small saturating count, and the block runs the owed refreshes when an access controller hands it the bus.

The bus handshake with the access controller is a request/grant pair. `refresh_req` stays high while at least one refresh is owed. The controller answers by holding `refresh_gnt` high only while it is idle and has released the strobes. A refresh starts on the first clock edge at which the grant is high, the sequencer is idle and a refresh is owed. `refresh_busy` then stays high until that cycle's precharge has ended. Back-pressure is simply a low grant: owed refreshes wait in the count, and the request stays up meanwhile. A grant given while nothing is owed starts nothing.

The sequencer supports two refresh styles, chosen by a parameter. In the default style, the column strobes drop before the row strobes and the DRAM keeps its own row counter. In the row-addressed style, the column strobes stay high and the block's own row counter is driven on the address pins. The row counter is a plain binary count, so its top bit changes least often. On a mixed-device module this means the rows selected by the lower bits recur twice per full sweep. All timing values are given in nanoseconds and converted to clock cycles through a clock-period parameter, rounding up.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted, all row and column strobes and the write enable are high, and `refresh_req`, `refresh_busy` and `init_done` are low.
- R2: No strobe moves before the power-up pause has elapsed. With a pause of P cycles counted from the first clock edge out of reset, the first cycle begins at edge P+1.
- R3: Exactly INIT_CYCLES (default 8) refresh cycles are issued back to back without any grant. `init_done` rises at the edge that ends the last one's precharge, which is tRP cycles after its row strobe rises, and stays high.
- R4: In the default style, CAS falls exactly the lead time (ceil of tCSR, at least 1 cycle) before RAS falls, and stays low while RAS is low. RAS stays low exactly max(tRAS, tCHR) cycles, and both strobes then rise on the same edge. RAS stays high at least tRP cycles before the next fall, and write enable stays high throughout.
- R5: All row strobe lines switch together, and all column strobe lines switch together.
- R6: After `init_done`, one refresh becomes owed every refresh-interval cycles, counting from the edge where `init_done` rose. The owed count saturates at PEND_MAX (default 4). After a long starvation with a continuous grant, exactly PEND_MAX cycles run before the request drops.
- R7: `refresh_req` is high exactly when the owed count is nonzero. A refresh after initialization starts only at an edge where the grant is high. While nothing is owed, the grant is ignored and no strobe moves.
- R8: When a refresh interval expires on the same edge as a refresh cycle completes, the owed count is unchanged.
- R9: The row counter starts at 0 and advances by one, with binary wrap-around, after every refresh cycle, initialization cycles included. On the address pins it reads k mod 2^ROW_BITS at the row strobe fall of the k-th cycle.
- R10: In the row-addressed style, CAS stays high at all times. The address is valid from the cycle before RAS falls and holds its value until RAS rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, also starts the power-up pause |
| refresh_gnt | input | 1 | Access controller grants the DRAM bus for a refresh |
| refresh_req | output | 1 | At least one refresh is owed |
| refresh_busy | output | 1 | A refresh or initialization cycle is in progress |
| init_done | output | 1 | Initialization burst complete, normal accesses allowed |
| ras_n | output | NUM_RAS | Row strobes, active low |
| cas_n | output | NUM_CAS | Column strobes, active low |
| we_n | output | 1 | Write enable, held high |
| row_addr | output | ROW_BITS | Refresh row counter, meaningful in row-addressed style |

## Verification
The owed-refresh count can be raised by an expiring interval and lowered by a completing cycle on the same clock edge. This is the collision that matters. It is provoked directly: with one refresh owed, a single-cycle grant is placed so that the cycle's precharge ends exactly on the next interval edge. Once the interval has expired, the request must still be high. A reference count in the bench follows every interval edge and every observed completion, also through long stretches of random grants where such collisions happen by chance. It judges the request on every cycle.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_ACT,
    ST_PRE
  } ref_state_t;

  // Nanoseconds to whole clock cycles, rounded up, never below one.
  function automatic int ns2cyc(input int ns, input int clk_ps);
    int c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/refresh_timer.sv
module refresh_timer #(
  parameter int PWR_CYC  = 20000,
  parameter int REFI_CYC = 1563
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic pwr_ok,
  output logic tick
);
  localparam int PW = $clog2(PWR_CYC + 1);
  localparam int TW = $clog2(REFI_CYC + 1);
  localparam logic [PW-1:0] PWR_LAST  = PW'(PWR_CYC - 1);
  localparam logic [TW-1:0] REFI_LAST = TW'(REFI_CYC - 1);

  logic [PW-1:0] pwr_cnt;
  logic [TW-1:0] tick_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_cnt <= '0;
      pwr_ok  <= 1'b0;
    end else if (!pwr_ok) begin
      if (pwr_cnt == PWR_LAST) pwr_ok <= 1'b1;
      else                     pwr_cnt <= pwr_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tick_cnt <= '0;
    else if (run)
      tick_cnt <= (tick_cnt == REFI_LAST) ? '0 : tick_cnt + 1'b1;
  end

  assign tick = run && (tick_cnt == REFI_LAST);

  assert_tick_after_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> pwr_ok);

endmodule

// File: rtl/pending_counter.sv
module pending_counter #(
  parameter int PEND_MAX = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic dec,
  output logic pend_nz
);
  localparam int CW = $clog2(PEND_MAX + 1);
  localparam logic [CW-1:0] CMAX = CW'(PEND_MAX);

  logic [CW-1:0] pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else begin
      case ({tick, dec})
        2'b10:   if (pend != CMAX) pend <= pend + 1'b1;
        2'b01:   if (pend != '0)   pend <= pend - 1'b1;
        default: pend <= pend;
      endcase
    end
  end

  assign pend_nz = (pend != '0);

  assert_pend_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= CMAX);
  assert_collision_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && dec) |=> $stable(pend));
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> pend_nz);

endmodule

// File: rtl/refresh_cycle_fsm.sv
module refresh_cycle_fsm
  import dram_refresh_pkg::*;
#(
  parameter int LEAD_CYC = 1,
  parameter int ACT_CYC  = 6,
  parameter int PRE_CYC  = 4,
  parameter bit RAS_ONLY = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic ras_act,
  output logic cas_act
);
  localparam int MAXL = (LEAD_CYC > ACT_CYC) ?
                        ((LEAD_CYC > PRE_CYC) ? LEAD_CYC : PRE_CYC) :
                        ((ACT_CYC > PRE_CYC) ? ACT_CYC : PRE_CYC);
  localparam int CW = $clog2(MAXL + 1);
  localparam logic [CW-1:0] LEAD_LAST = CW'(LEAD_CYC - 1);
  localparam logic [CW-1:0] ACT_LAST  = CW'(ACT_CYC - 1);
  localparam logic [CW-1:0] PRE_LAST  = CW'(PRE_CYC - 1);

  ref_state_t    st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin st <= ST_LEAD; cnt <= '0; end
        ST_LEAD: if (cnt == LEAD_LAST) begin st <= ST_ACT; cnt <= '0; end
                 else cnt <= cnt + 1'b1;
        ST_ACT:  if (cnt == ACT_LAST) begin st <= ST_PRE; cnt <= '0; end
                 else cnt <= cnt + 1'b1;
        default: if (cnt == PRE_LAST) begin st <= ST_IDLE; cnt <= '0; end
                 else cnt <= cnt + 1'b1;
      endcase
    end
  end

  assign busy    = (st != ST_IDLE);
  assign done    = (st == ST_PRE) && (cnt == PRE_LAST);
  assign ras_act = (st == ST_ACT);
  assign cas_act = !RAS_ONLY && ((st == ST_LEAD) || (st == ST_ACT));

  // Checker: length of each row strobe pulse.
  logic [CW-1:0] low_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       low_len <= '0;
    else if (ras_act) low_len <= low_len + 1'b1;
    else              low_len <= '0;
  end

  assert_ras_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_act) |-> (low_len == CW'(ACT_CYC)));
  assert_cas_leads_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!RAS_ONLY && $rose(ras_act)) |-> $past(cas_act));
  assert_cas_with_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!RAS_ONLY && $fell(ras_act)) |-> !cas_act);

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_refresh_pkg::*;
#(
  parameter int CLK_PERIOD_PS       = 10000,
  parameter int POWERUP_NS          = 200000,
  parameter int REFRESH_INTERVAL_NS = 15625,
  parameter int INIT_CYCLES         = 8,
  parameter int ROW_BITS            = 11,
  parameter int PEND_MAX            = 4,
  parameter int NUM_RAS             = 4,
  parameter int NUM_CAS             = 4,
  parameter bit RAS_ONLY            = 1'b0,
  parameter int T_CSR_NS            = 5,
  parameter int T_ASR_NS            = 0,
  parameter int T_CHR_NS            = 10,
  parameter int T_RAS_NS            = 60,
  parameter int T_RP_NS             = 40
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                refresh_gnt,
  output logic                refresh_req,
  output logic                refresh_busy,
  output logic                init_done,
  output logic [NUM_RAS-1:0]  ras_n,
  output logic [NUM_CAS-1:0]  cas_n,
  output logic                we_n,
  output logic [ROW_BITS-1:0] row_addr
);
  localparam int PWR_CYC  = ns2cyc(POWERUP_NS, CLK_PERIOD_PS);
  localparam int REFI_CYC = ns2cyc(REFRESH_INTERVAL_NS, CLK_PERIOD_PS);
  localparam int LEAD_CYC = RAS_ONLY ? ns2cyc(T_ASR_NS, CLK_PERIOD_PS)
                                     : ns2cyc(T_CSR_NS, CLK_PERIOD_PS);
  localparam int RAS_CYC  = ns2cyc(T_RAS_NS, CLK_PERIOD_PS);
  localparam int CHR_CYC  = ns2cyc(T_CHR_NS, CLK_PERIOD_PS);
  localparam int ACT_CYC  = (RAS_CYC > CHR_CYC) ? RAS_CYC : CHR_CYC;
  localparam int PRE_CYC  = ns2cyc(T_RP_NS, CLK_PERIOD_PS);
  localparam int IW       = $clog2(INIT_CYCLES + 1);
  localparam logic [IW-1:0] INIT_LAST = IW'(INIT_CYCLES - 1);

  logic          pwr_ok, tick, pend_nz;
  logic          busy, done, ras_act, cas_act, start;
  logic [IW-1:0] init_cnt;
  logic [ROW_BITS-1:0] row_q;

  refresh_timer #(.PWR_CYC(PWR_CYC), .REFI_CYC(REFI_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(init_done), .pwr_ok(pwr_ok), .tick(tick));

  pending_counter #(.PEND_MAX(PEND_MAX)) u_pend (
    .clk(clk), .rst_n(rst_n), .tick(tick), .dec(done && init_done),
    .pend_nz(pend_nz));

  refresh_cycle_fsm #(.LEAD_CYC(LEAD_CYC), .ACT_CYC(ACT_CYC),
                      .PRE_CYC(PRE_CYC), .RAS_ONLY(RAS_ONLY)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .ras_act(ras_act), .cas_act(cas_act));

  // Initialization runs unconditionally; afterwards a cycle needs a grant.
  assign start = !busy && pwr_ok &&
                 (init_done ? (pend_nz && refresh_gnt) : 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_cnt  <= '0;
      init_done <= 1'b0;
    end else if (done && !init_done) begin
      init_cnt <= init_cnt + 1'b1;
      if (init_cnt == INIT_LAST) init_done <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    row_q <= '0;
    else if (done) row_q <= row_q + 1'b1;
  end

  for (genvar i = 0; i < NUM_RAS; i++) begin : g_ras
    assign ras_n[i] = ~ras_act;
  end
  for (genvar j = 0; j < NUM_CAS; j++) begin : g_cas
    assign cas_n[j] = ~cas_act;
  end

  assign we_n         = 1'b1;
  assign row_addr     = row_q;
  assign refresh_req  = pend_nz;
  assign refresh_busy = busy;

  assert_quiet_before_powerup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |-> (&ras_n && &cas_n));
  assert_init_done_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  assert_start_needs_gnt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(refresh_busy) && init_done) |-> $past(refresh_gnt));
  assert_row_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (row_q == ($past(row_q) + 1'b1)));
  assert_row_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (RAS_ONLY && !ras_n[0]) |-> (&cas_n && $stable(row_addr)));

endmodule

// File: tb/dram_refresh_seq_tb.sv
module dram_refresh_seq_tb;
  localparam int CLK_PS  = 10000;
  localparam int PWR_NS  = 3000;
  localparam int REFI_NS = 1000;

  function automatic int cyc_of(input int ns);
    int c;
    c = (ns * 1000 + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int PWR   = cyc_of(PWR_NS);
  localparam int REFI  = cyc_of(REFI_NS);
  localparam int L1    = cyc_of(5);
  localparam int LR    = (cyc_of(60) > cyc_of(10)) ? cyc_of(60) : cyc_of(10);
  localparam int LP    = cyc_of(40);
  localparam int PMAX  = 4;
  localparam int INITN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gnt = 1'b0;
  logic req, busy, idone, we_n;
  logic [3:0] ras_n, cas_n;
  logic [10:0] addr;
  logic req_ro, busy_ro, idone_ro, we_ro;
  logic [3:0] ras_ro, cas_ro;
  logic [3:0] addr_ro;

  always #5 clk = ~clk;

  dram_refresh_seq #(.CLK_PERIOD_PS(CLK_PS), .POWERUP_NS(PWR_NS),
                     .REFRESH_INTERVAL_NS(REFI_NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .refresh_gnt(gnt), .refresh_req(req),
    .refresh_busy(busy), .init_done(idone), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .row_addr(addr));

  dram_refresh_seq #(.CLK_PERIOD_PS(CLK_PS), .POWERUP_NS(PWR_NS),
                     .REFRESH_INTERVAL_NS(REFI_NS), .ROW_BITS(4),
                     .RAS_ONLY(1'b1)) u_dut_ro (
    .clk(clk), .rst_n(rst_n), .refresh_gnt(1'b1), .refresh_req(req_ro),
    .refresh_busy(busy_ro), .init_done(idone_ro), .ras_n(ras_ro),
    .cas_n(cas_ro), .we_n(we_ro), .row_addr(addr_ro));

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [7:0] gh = '0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) cyc <= cyc + 1;
    gh <= {gh[6:0], gnt};
  end

  // Monitor of the default-style instance and reference owed count.
  logic pr_ras = 1'b1, pr_cas = 1'b1, pr_idone = 1'b0;
  int cas_fall_e = 0, ras_fall_e = 0, ras_rise_e = -100;
  int falls = 0, init_falls = 0, first_cas = -1;
  int e0 = -1, dec_at = -1, mpend = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit inc, dec;
      if (pr_cas && !cas_n[0]) begin
        cas_fall_e = cyc;
        if (first_cas < 0) begin
          first_cas = cyc;
          chk(cyc == PWR + 1, "R2 first strobe edge", cyc, PWR + 1);
        end
      end
      if (pr_ras && !ras_n[0]) begin
        chk(cyc - cas_fall_e == L1, "R4 cas lead", cyc - cas_fall_e, L1);
        chk(ras_n == 4'h0 && cas_n == 4'h0, "R5 strobes together", ras_n, 0);
        chk(we_n == 1'b1, "R4 write enable high", we_n, 1);
        chk(cyc - ras_rise_e >= LP, "R4 precharge width", cyc - ras_rise_e, LP);
        chk(addr == 11'(falls), "R9 row order", addr, falls % 2048);
        if (!idone) init_falls++;
        else chk(gh[L1] == 1'b1, "R7 start needs grant", gh[L1], 1);
        falls++;
        ras_fall_e = cyc;
      end
      if (!pr_ras && ras_n[0]) begin
        chk(cyc - ras_fall_e == LR, "R4 ras width", cyc - ras_fall_e, LR);
        chk(ras_n == 4'hF && cas_n == 4'hF, "R4 cas rises with ras", cas_n, 15);
        ras_rise_e = cyc;
        if (idone) dec_at = cyc + LP;
      end
      if (!pr_idone && idone) begin
        e0 = cyc;
        chk(cyc == ras_rise_e + LP, "R3 init_done edge", cyc, ras_rise_e + LP);
        chk(init_falls == INITN, "R3 init cycle count", init_falls, INITN);
      end
      if (pr_idone) chk(idone == 1'b1, "R3 init_done sticky", idone, 1);
      inc = (e0 >= 0) && (cyc > e0) && ((cyc - e0) % REFI == 0);
      dec = (cyc == dec_at);
      if (inc && !dec && mpend < PMAX) mpend++;
      else if (dec && !inc && mpend > 0) mpend--;
      chk(req == (mpend != 0), "R7 request tracks owed count", req, mpend != 0);
      pr_ras = ras_n[0];
      pr_cas = cas_n[0];
      pr_idone = idone;
    end
  end

  // Monitor of the row-addressed instance.
  logic pr_ras_ro = 1'b1, pb1 = 1'b0, pb2 = 1'b0;
  int ro_falls = 0;
  logic [3:0] ro_fall_addr = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (cas_ro != 4'hF) chk(1'b0, "R10 cas held high", cas_ro, 15);
      if (pr_ras_ro && !ras_ro[0]) begin
        chk(addr_ro == 4'(ro_falls), "R9 row wrap order", addr_ro, ro_falls % 16);
        chk(pb1 == 1'b1 && pb2 == 1'b0, "R10 address lead cycle", {pb2, pb1}, 1);
        ro_fall_addr = addr_ro;
        ro_falls++;
      end
      if (!pr_ras_ro && ras_ro[0])
        chk(addr_ro == ro_fall_addr, "R10 address held", addr_ro, ro_fall_addr);
      pr_ras_ro = ras_ro[0];
      pb2 = pb1;
      pb1 = busy_ro;
    end
  end

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
    finish_run();
  end

  initial begin
    int unsigned seed;
    int f0, t1, t2, s;
    seed = $urandom(32'h1F2E);
    repeat (3) @(negedge clk);
    chk(ras_n == 4'hF && cas_n == 4'hF && we_n, "R1 reset strobes", ras_n, 15);
    chk(!req && !busy && !idone, "R1 reset flags", {req, busy, idone}, 0);
    rst_n = 1'b1;
    while (!idone) @(negedge clk);

    // Random grants.
    repeat (3000) begin
      @(negedge clk);
      gnt = ($urandom % 4) == 0;
    end

    // Starvation, then drain with a continuous grant.
    gnt = 1'b0;
    f0 = falls;
    repeat (6 * REFI) @(negedge clk);
    chk(falls == f0, "R7 no cycle without grant", falls - f0, 0);
    chk(req == 1'b1, "R7 request held while starved", req, 1);
    while (((cyc - e0) % REFI) != 2) @(negedge clk);
    f0 = falls;
    gnt = 1'b1;
    while (req) @(negedge clk);
    gnt = 1'b0;
    repeat (LP + 2) @(negedge clk);
    chk(falls - f0 == PMAX, "R6 saturated owed count", falls - f0, PMAX);

    // Grant with nothing owed is ignored.
    f0 = falls;
    gnt = 1'b1;
    repeat (20) @(negedge clk);
    gnt = 1'b0;
    chk(falls == f0 && !busy, "R7 idle grant ignored", falls - f0, 0);

    // Interval expiry on the completion edge.
    t1 = e0 + ((cyc - e0) / REFI + 1) * REFI;
    t2 = t1 + REFI;
    s  = t2 - (L1 + LR + LP);
    while (cyc != s - 1) @(negedge clk);
    gnt = 1'b1;
    @(negedge clk);
    gnt = 1'b0;
    chk(busy == 1'b1, "R7 single-edge grant starts cycle", busy, 1);
    while (cyc != t2) @(negedge clk);
    chk(req == 1'b1, "R8 collision keeps request", req, 1);
    chk(mpend == 1, "R8 reference count after collision", mpend, 1);
    gnt = 1'b1;
    while (req) @(negedge clk);
    gnt = 1'b0;
    repeat (20) @(negedge clk);
    chk(ro_falls >= 20, "R9 row counter wrapped", ro_falls, 20);
    finish_run();
  end

endmodule